// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, for each of the two ALU operands of the instruction in the execute stage of a five-stage pipeline, where the operand value comes from. It compares the two source register numbers of that instruction with the destination register numbers of the two older instructions still in flight. One older instruction sits between execute and memory access. The other sits between memory access and write-back. A 2-bit select for each operand steers the operand mux to one of three values: the register-file read, the result held after execute, or the value about to be written back.

The unit is purely combinational and has no state. The selects follow the inputs within the same cycle, so the operand muxes can settle before the ALU does. An older instruction takes part only if it writes the register file and its destination is not register zero. When both older instructions qualify for the same source, the one nearer to execute holds the newer value and wins. The two operands are resolved separately, so one may be bypassed while the other is not, or both may be bypassed from the same stage or from different stages.

Select encoding, used by both operand outputs: `2'b00` selects the register-file value, `2'b10` selects the execute/memory result, and `2'b01` selects the memory/write-back value. `2'b11` is never produced.

Top module: `fwd_unit`

## Requirements
- R1: When neither older instruction qualifies for a source, that operand's select is 2'b00 (register file).
- R2: When the execute/memory instruction writes, its destination is nonzero and equals the first source, `fwd_a` is 2'b10.
- R3: When the execute/memory instruction writes, its destination is nonzero and equals the second source, `fwd_b` is 2'b10.
- R4: When only the memory/write-back instruction qualifies for the first source (it writes, its destination is nonzero and equal to the source), `fwd_a` is 2'b01.
- R5: When only the memory/write-back instruction qualifies for the second source, `fwd_b` is 2'b01.
- R6: When both older instructions qualify for the same source, that operand's select is 2'b10 (the newer result wins).
- R7: An older instruction whose write enable is low never causes a bypass from its stage; a qualifying other stage is still used.
- R8: A destination of register zero never causes a bypass, even when it equals the source and the write enable is high.
- R9: The two operands are resolved independently, so both selects may be nonzero in the same cycle, from the same stage or from different stages.
- R10: Neither select ever takes the value 2'b11.
- R11: The selects depend only on the present inputs, with no clock or state: a change of inputs is reflected in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_rs | input | REG_ADDR_W | First source register number of the execute-stage instruction |
| ex_rt | input | REG_ADDR_W | Second source register number of the execute-stage instruction |
| mem_rd | input | REG_ADDR_W | Destination register number of the execute/memory instruction |
| mem_wen | input | 1 | Register-file write enable of the execute/memory instruction |
| wb_rd | input | REG_ADDR_W | Destination register number of the memory/write-back instruction |
| wb_wen | input | 1 | Register-file write enable of the memory/write-back instruction |
| fwd_a | output | 2 | Source select for the first ALU operand |
| fwd_b | output | 2 | Source select for the second ALU operand |

## Verification
The bench builds the unit with `REG_ADDR_W` set to 3 rather than the default 5. With only eight register numbers, every combination of the two sources, the two destinations and the two write enables can be applied: 16384 patterns, each compared with an independent model. The sweep therefore reaches every alias between sources and destinations, including register zero and the case where both sources name the same register. The directed scenarios then cover each requirement by name with hand-picked patterns.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    // Operand source select, shared by both ALU operands.
    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_WB      = 2'b01,
        SRC_MEM     = 2'b10
    } fwd_sel_e;

    // Number of ALU operands resolved by the unit.
    localparam int unsigned NUM_OPERANDS = 2;

endpackage

// File: rtl/fwd_producer_qual.sv
// Decides whether an older in-flight instruction may supply a bypass value:
// it must write the register file and must not target register zero.
module fwd_producer_qual #(
    parameter int unsigned REG_ADDR_W = 5
) (
    input  logic [REG_ADDR_W-1:0] rd,
    input  logic                  wen,
    output logic                  qualified
);
    localparam logic [REG_ADDR_W-1:0] ZERO_REG = '0;

    always_comb begin
        qualified = wen && (rd != ZERO_REG);
    end
endmodule

// File: rtl/fwd_src_match.sv
// Compares one source register number with one producer destination.
module fwd_src_match #(
    parameter int unsigned REG_ADDR_W = 5
) (
    input  logic [REG_ADDR_W-1:0] src,
    input  logic [REG_ADDR_W-1:0] rd,
    input  logic                  producer_ok,
    output logic                  hit
);
    always_comb begin
        hit = producer_ok && (src == rd);
    end
endmodule

// File: rtl/fwd_operand_sel.sv
// Turns the two stage hits of one operand into a select; newer stage wins.
module fwd_operand_sel
    import fwd_pkg::*;
(
    input  logic     mem_hit,
    input  logic     wb_hit,
    output fwd_sel_e sel
);
    always_comb begin
        unique case ({mem_hit, wb_hit})
            2'b10, 2'b11: sel = SRC_MEM;
            2'b01:        sel = SRC_WB;
            default:      sel = SRC_REGFILE;
        endcase
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int unsigned REG_ADDR_W = 5
) (
    input  logic [REG_ADDR_W-1:0] ex_rs,
    input  logic [REG_ADDR_W-1:0] ex_rt,
    input  logic [REG_ADDR_W-1:0] mem_rd,
    input  logic                  mem_wen,
    input  logic [REG_ADDR_W-1:0] wb_rd,
    input  logic                  wb_wen,
    output logic [1:0]            fwd_a,
    output logic [1:0]            fwd_b
);
    logic                  mem_ok;
    logic                  wb_ok;
    logic [REG_ADDR_W-1:0] src     [NUM_OPERANDS];
    fwd_sel_e              sel     [NUM_OPERANDS];
    logic                  mem_hit [NUM_OPERANDS];
    logic                  wb_hit  [NUM_OPERANDS];

    assign src[0] = ex_rs;
    assign src[1] = ex_rt;

    fwd_producer_qual #(.REG_ADDR_W(REG_ADDR_W)) u_mem_qual (
        .rd        (mem_rd),
        .wen       (mem_wen),
        .qualified (mem_ok)
    );

    fwd_producer_qual #(.REG_ADDR_W(REG_ADDR_W)) u_wb_qual (
        .rd        (wb_rd),
        .wen       (wb_wen),
        .qualified (wb_ok)
    );

    for (genvar op = 0; op < NUM_OPERANDS; op++) begin : g_operand
        fwd_src_match #(.REG_ADDR_W(REG_ADDR_W)) u_mem_match (
            .src         (src[op]),
            .rd          (mem_rd),
            .producer_ok (mem_ok),
            .hit         (mem_hit[op])
        );

        fwd_src_match #(.REG_ADDR_W(REG_ADDR_W)) u_wb_match (
            .src         (src[op]),
            .rd          (wb_rd),
            .producer_ok (wb_ok),
            .hit         (wb_hit[op])
        );

        fwd_operand_sel u_sel (
            .mem_hit (mem_hit[op]),
            .wb_hit  (wb_hit[op]),
            .sel     (sel[op])
        );
    end

    assign fwd_a = sel[0];
    assign fwd_b = sel[1];
endmodule

// File: rtl/fwd_unit_chk.sv
// Port-level checks of the bypass selector, bound to every instance.
module fwd_unit_chk #(
    parameter int unsigned REG_ADDR_W = 5
) (
    input logic [REG_ADDR_W-1:0] ex_rs,
    input logic [REG_ADDR_W-1:0] ex_rt,
    input logic [REG_ADDR_W-1:0] mem_rd,
    input logic                  mem_wen,
    input logic [REG_ADDR_W-1:0] wb_rd,
    input logic                  wb_wen,
    input logic [1:0]            fwd_a,
    input logic [1:0]            fwd_b
);
    localparam logic [REG_ADDR_W-1:0] ZERO_REG = '0;

    always_comb begin
        // R10: encoding 2'b11 is never produced
        assert_sel_legal_R10: assert ((fwd_a != 2'b11) && (fwd_b != 2'b11));

        // R8: any bypass implies a nonzero source register
        assert_zero_reg_a_R8: assert ((fwd_a == 2'b00) || (ex_rs != ZERO_REG));
        assert_zero_reg_b_R8: assert ((fwd_b == 2'b00) || (ex_rt != ZERO_REG));

        // R7: a stage bypass implies that stage writes
        assert_mem_wen_R7: assert (!((fwd_a == 2'b10) || (fwd_b == 2'b10)) || mem_wen);
        assert_wb_wen_R7: assert (!((fwd_a == 2'b01) || (fwd_b == 2'b01)) || wb_wen);

        // R2, R6: a writing, nonzero, matching execute/memory stage is chosen
        assert_mem_pri_R6: assert (!(mem_wen && (mem_rd != ZERO_REG) && (mem_rd == ex_rs))
                                    || (fwd_a == 2'b10));
        // R3
        assert_mem_b_R3: assert (!(mem_wen && (mem_rd != ZERO_REG) && (mem_rd == ex_rt))
                                  || (fwd_b == 2'b10));
        // R4: write-back bypass only when its destination names the source
        assert_wb_a_R4: assert ((fwd_a != 2'b01) || (wb_rd == ex_rs));
        // R5
        assert_wb_b_R5: assert ((fwd_b != 2'b01) || (wb_rd == ex_rt));
    end
endmodule

bind fwd_unit fwd_unit_chk #(.REG_ADDR_W(REG_ADDR_W)) u_fwd_chk (
    .ex_rs   (ex_rs),
    .ex_rt   (ex_rt),
    .mem_rd  (mem_rd),
    .mem_wen (mem_wen),
    .wb_rd   (wb_rd),
    .wb_wen  (wb_wen),
    .fwd_a   (fwd_a),
    .fwd_b   (fwd_b)
);

// File: tb/tb_fwd_unit.sv
`timescale 1ns/1ps
module tb_fwd_unit;
    localparam int unsigned W = 3;

    logic         clk = 1'b0;
    logic [W-1:0] ex_rs, ex_rt, mem_rd, wb_rd;
    logic         mem_wen, wb_wen;
    logic [1:0]   fwd_a, fwd_b;
    int           n_checks = 0;
    int           n_fail   = 0;
    bit           done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    fwd_unit #(.REG_ADDR_W(W)) dut (
        .ex_rs(ex_rs), .ex_rt(ex_rt), .mem_rd(mem_rd), .mem_wen(mem_wen),
        .wb_rd(wb_rd), .wb_wen(wb_wen), .fwd_a(fwd_a), .fwd_b(fwd_b)
    );

    // Independent model, written from the requirements.
    function automatic logic [1:0] model(input logic [W-1:0] s,
                                         input logic [W-1:0] md, input logic mw,
                                         input logic [W-1:0] wd, input logic ww);
        if (mw && md != 0 && md == s) return 2'b10;
        if (ww && wd != 0 && wd == s) return 2'b01;
        return 2'b00;
    endfunction

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b (rs=%0d rt=%0d mrd=%0d mw=%b wrd=%0d ww=%b)",
                     req, act, exp, ex_rs, ex_rt, mem_rd, mem_wen, wb_rd, wb_wen);
        end
    endtask

    // Drive on a rising edge, sample on the following falling edge.
    task automatic apply(input int rs, input int rt, input int md, input bit mw,
                         input int wd, input bit ww);
        @(posedge clk);
        ex_rs = W'(rs); ex_rt = W'(rt); mem_rd = W'(md); mem_wen = mw;
        wb_rd = W'(wd); wb_wen = ww;
        @(negedge clk);
    endtask

    task automatic t_idle();
        apply(0, 0, 0, 0, 0, 0);
        check("R1 idle a", fwd_a, 2'b00);
        check("R1 idle b", fwd_b, 2'b00);
        apply(1, 2, 3, 1, 4, 1);
        check("R1 no match a", fwd_a, 2'b00);
        check("R1 no match b", fwd_b, 2'b00);
    endtask

    task automatic t_mem_fwd();
        apply(5, 2, 5, 1, 0, 0);
        check("R2 mem to a", fwd_a, 2'b10);
        check("R2 b untouched", fwd_b, 2'b00);
        apply(1, 6, 6, 1, 0, 0);
        check("R3 mem to b", fwd_b, 2'b10);
        check("R3 a untouched", fwd_a, 2'b00);
    endtask

    task automatic t_wb_fwd();
        apply(3, 1, 7, 1, 3, 1);
        check("R4 wb to a", fwd_a, 2'b01);
        apply(2, 4, 7, 1, 4, 1);
        check("R5 wb to b", fwd_b, 2'b01);
    endtask

    task automatic t_priority();
        apply(6, 6, 6, 1, 6, 1);
        check("R6 newer wins a", fwd_a, 2'b10);
        check("R6 newer wins b", fwd_b, 2'b10);
    endtask

    task automatic t_wen_low();
        apply(4, 4, 4, 0, 4, 1);
        check("R7 mem disabled, wb used", fwd_a, 2'b01);
        apply(4, 2, 4, 0, 4, 0);
        check("R7 both disabled", fwd_a, 2'b00);
    endtask

    task automatic t_zero_reg();
        apply(0, 0, 0, 1, 0, 1);
        check("R8 zero reg a", fwd_a, 2'b00);
        check("R8 zero reg b", fwd_b, 2'b00);
        apply(0, 5, 0, 1, 5, 1);
        check("R8 zero a, wb b", fwd_a, 2'b00);
        check("R8 wb b kept", fwd_b, 2'b01);
    endtask

    task automatic t_both_ops();
        apply(2, 3, 2, 1, 3, 1);
        check("R9 a from mem", fwd_a, 2'b10);
        check("R9 b from wb", fwd_b, 2'b01);
        apply(7, 1, 1, 1, 7, 1);
        check("R9 a from wb", fwd_a, 2'b01);
        check("R9 b from mem", fwd_b, 2'b10);
    endtask

    task automatic t_same_cycle();
        apply(3, 0, 3, 1, 0, 0);
        check("R11 first pattern", fwd_a, 2'b10);
        apply(3, 0, 3, 0, 0, 0);
        check("R11 follows next cycle inputs", fwd_a, 2'b00);
    endtask

    task automatic t_sweep();
        for (int v = 0; v < (1 << (4*W + 2)); v++) begin
            apply(v & 7, (v >> 3) & 7, (v >> 6) & 7, v[12], (v >> 9) & 7, v[13]);
            check("R10 sweep a", fwd_a, model(ex_rs, mem_rd, mem_wen, wb_rd, wb_wen));
            check("R10 sweep b", fwd_b, model(ex_rt, mem_rd, mem_wen, wb_rd, wb_wen));
        end
    endtask

    initial begin
        ex_rs = '0; ex_rt = '0; mem_rd = '0; wb_rd = '0; mem_wen = 1'b0; wb_wen = 1'b0;
        t_idle();
        t_mem_fwd();
        t_wb_fwd();
        t_priority();
        t_wen_low();
        t_zero_reg();
        t_both_ops();
        t_same_cycle();
        t_sweep();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule